// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block generates the address of the next microinstruction in a microprogrammed control unit. A 9-bit microprogram counter selects a row of a small built-in control store. After each microinstruction the counter normally steps by one. Four events can override that step. When a new machine instruction arrives in the instruction register, the counter jumps to the entry point of that instruction's microroutine. A branch microinstruction whose selected condition holds sends the counter to its target. An end microinstruction sends it back to the fetch routine. A microinstruction that waits for memory freezes the counter until the memory reports completion.

Branch targets can be steered by the addressing mode of the current instruction. Selected instruction-register bits are ORed into the low bits of the target, so a single branch fans out to several neighbouring rows with no extra dispatch step. The block also gates register operands in two stages. A control-word bit picks the source or the destination field of the instruction register, and that 4-bit field is then decoded into one of 16 register enables. The control store contents are a fixed table for test. Decoding the remaining control-word fields belongs to the surrounding unit.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `upc` is 000 (octal), `reg_gate` is zero, and `uop_end` and `uop_wait` are low.
- R2: When none of the rules R3, R4, R5 or R7 applies, `upc` becomes `upc + 1` at the next clock edge.
- R3: When `ir_load` is high, the instruction register captures `ir_word`, and `upc` becomes `{0, ir_word[15:11], 000}` (opcode times 8) at the next edge, unless R7 holds it.
- R4: When the current row is an end row and `ir_load` is low, `upc` becomes 000 at the next edge, unless R7 holds it.
- R5: A branch row carries a 2-bit condition select: 00 always, 01 `flag_n`, 10 `flag_z`, 11 `ext_cond`. A taken branch loads the target. An untaken branch increments.
- R6: A branch row carries a 2-bit OR select that is applied to its target using the stored instruction register. 00 leaves the target unchanged. 01 ORs the inverse of IR[8] (high means direct) into bit 0. 10 ORs IR[10:9] (the source mode: 11 indexed, 10 autodecrement, 01 autoincrement, 00 register) into bits 1:0. 11 ORs {IR[10:9], ~IR[8]} into bits 2:0.
- R7: While the current row has its wait bit set (`uop_wait` high) and `mfc` is low, `upc` holds its value, even if the row branches or `ir_load` is high.
- R8: `ir_load` takes priority over end and over a taken branch.
- R9: On a gating row, `reg_gate` is one-hot. The bit chosen is IR[7:4] on a source row or IR[3:0] on a destination row. On any other row `reg_gate` is zero.
- R10: The test table, in octal, is as follows. 001 waits. 003 ends. 010 branches always to 170 with OR select 01. 171 ends. 020 branches on N to 100. 021 ends. 030 branches on Z to 104 with OR select 10. 031 ends. 040 branches on the external input to 120 with OR select 11. 041 ends. 050 waits and branches always to 130. 060 gates the source register. 061 gates the destination register. 062 ends. Rows 100 to 137 end. All other rows step by one. `uop_end` and `uop_wait` show the end and wait bits of the current row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_load | input | 1 | A new instruction is present on `ir_word` |
| ir_word | input | 16 | Instruction word: opcode [15:11], mode [10:9], indirect [8], source reg [7:4], destination reg [3:0] |
| flag_n | input | 1 | Negative condition code |
| flag_z | input | 1 | Zero condition code |
| ext_cond | input | 1 | External branch condition |
| mfc | input | 1 | Memory function completed |
| upc | output | 9 | Current microinstruction address |
| uop_end | output | 1 | End bit of the current row |
| uop_wait | output | 1 | Wait-for-memory bit of the current row |
| reg_gate | output | 16 | One-hot register gating enables |

## Verification
The assertions assume that `mfc`, `ir_load` and `ir_word` are stable around the clock edge. They also assume that the opcode on `ir_word` is meaningful only when `ir_load` is high. The bench drives every input one time unit after the rising edge and keeps it unchanged until the next edge. It asserts `ir_load` at only a few deliberate points, including one wait cycle, one end row and one branch row. These cases test the freeze and the priority rules. Every opcode used is one whose entry row exists in the test table.

// File: rtl/useq_pkg.sv
// Shared widths, the microinstruction record and field encodings for the
// microprogram sequencer. Assumes a 16-bit instruction word with the opcode
// in the top bits.
package useq_pkg;
    parameter int UAW     = 9;   // microaddress width
    parameter int IRW     = 16;  // instruction register width
    parameter int OPW     = 5;   // opcode width
    parameter int OP_LSB  = 11;  // opcode position
    parameter int MODE_LSB = 9;  // source mode field position (2 bits)
    parameter int IND_BIT = 8;   // indirect flag position
    parameter int RW      = 4;   // register select width
    parameter int SRC_LSB = 4;   // source register field position
    parameter int DST_LSB = 0;   // destination register field position
    localparam int NREG   = 1 << RW;
    localparam int SLOTB  = UAW - OPW - 1; // low zero bits of an entry address

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_NEG    = 2'b01,
        COND_ZERO   = 2'b10,
        COND_EXT    = 2'b11
    } cond_sel_e;

    typedef enum logic [1:0] {
        ORM_NONE   = 2'b00,
        ORM_DIRECT = 2'b01,
        ORM_MODE   = 2'b10,
        ORM_BOTH   = 2'b11
    } or_sel_e;

    typedef struct packed {
        logic            end_op;
        logic            wait_mem;
        logic            branch;
        cond_sel_e       cond_sel;
        or_sel_e         or_sel;
        logic [UAW-1:0]  target;
        logic            reg_en;
        logic            reg_dst;
    } uinstr_t;
endpackage

// File: rtl/useq_store.sv
// Built-in test control store: maps a microaddress to its sequencing and
// register-gating fields. Purely combinational; rows not listed step by one.
module useq_store
    import useq_pkg::*;
(
    input  logic [UAW-1:0] addr,
    output uinstr_t        uw
);
    // Row lookup
    always_comb begin
        uw = '0;
        uw.cond_sel = COND_ALWAYS;
        uw.or_sel   = ORM_NONE;
        if (addr >= UAW'(9'o100) && addr <= UAW'(9'o137)) uw.end_op = 1'b1;
        case (addr)
            UAW'(9'o001): uw.wait_mem = 1'b1;
            UAW'(9'o003): uw.end_op   = 1'b1;
            UAW'(9'o010): begin
                uw.branch = 1'b1; uw.target = UAW'(9'o170); uw.or_sel = ORM_DIRECT;
            end
            UAW'(9'o171): uw.end_op = 1'b1;
            UAW'(9'o020): begin
                uw.branch = 1'b1; uw.cond_sel = COND_NEG; uw.target = UAW'(9'o100);
            end
            UAW'(9'o021): uw.end_op = 1'b1;
            UAW'(9'o030): begin
                uw.branch = 1'b1; uw.cond_sel = COND_ZERO;
                uw.target = UAW'(9'o104); uw.or_sel = ORM_MODE;
            end
            UAW'(9'o031): uw.end_op = 1'b1;
            UAW'(9'o040): begin
                uw.branch = 1'b1; uw.cond_sel = COND_EXT;
                uw.target = UAW'(9'o120); uw.or_sel = ORM_BOTH;
            end
            UAW'(9'o041): uw.end_op = 1'b1;
            UAW'(9'o050): begin
                uw.wait_mem = 1'b1; uw.branch = 1'b1; uw.target = UAW'(9'o130);
            end
            UAW'(9'o060): uw.reg_en = 1'b1;
            UAW'(9'o061): begin
                uw.reg_en = 1'b1; uw.reg_dst = 1'b1;
            end
            UAW'(9'o062): uw.end_op = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/useq_start_gen.sv
// Starting-address generator: turns the opcode of an incoming instruction
// into its microroutine entry (opcode times 2**SLOTB). Assumes every opcode
// owns an aligned block of rows.
module useq_start_gen
    import useq_pkg::*;
(
    input  logic [IRW-1:0] ir_word,
    output logic [UAW-1:0] start_addr
);
    // Entry address from opcode
    always_comb begin
        start_addr = {1'b0, ir_word[OP_LSB +: OPW], {SLOTB{1'b0}}};
    end
endmodule

// File: rtl/useq_next.sv
// Next-address selection: wait freeze, then new instruction, then end,
// then taken branch (with mode bits ORed into the target), else increment.
// Assumes the stored instruction register holds the current instruction.
module useq_next
    import useq_pkg::*;
(
    input  logic [UAW-1:0] upc,
    input  uinstr_t        uw,
    input  logic           ir_load,
    input  logic [UAW-1:0] start_addr,
    input  logic [IRW-1:0] ir_q,
    input  logic           flag_n,
    input  logic           flag_z,
    input  logic           ext_cond,
    input  logic           mfc,
    output logic [UAW-1:0] upc_nxt
);
    logic           cond_ok;
    logic [UAW-1:0] or_bits;
    logic           direct;
    logic [1:0]     mode;

    // Condition multiplexer
    always_comb begin
        unique case (uw.cond_sel)
            COND_ALWAYS: cond_ok = 1'b1;
            COND_NEG:    cond_ok = flag_n;
            COND_ZERO:   cond_ok = flag_z;
            default:     cond_ok = ext_cond;
        endcase
    end

    // Mode bits to OR into a branch target
    always_comb begin
        direct = ~ir_q[IND_BIT];
        mode   = ir_q[MODE_LSB +: 2];
        unique case (uw.or_sel)
            ORM_NONE:   or_bits = '0;
            ORM_DIRECT: or_bits = {{(UAW-1){1'b0}}, direct};
            ORM_MODE:   or_bits = {{(UAW-2){1'b0}}, mode};
            default:    or_bits = {{(UAW-3){1'b0}}, mode, direct};
        endcase
    end

    // Priority selection of the next microaddress
    always_comb begin
        if (uw.wait_mem && !mfc)        upc_nxt = upc;
        else if (ir_load)               upc_nxt = start_addr;
        else if (uw.end_op)             upc_nxt = '0;
        else if (uw.branch && cond_ok)  upc_nxt = uw.target | or_bits;
        else                            upc_nxt = upc + UAW'(1);
    end
endmodule

// File: rtl/useq_reg_dec.sv
// Two-stage register gating: the control word picks the source or
// destination field of the instruction register, then that field is
// decoded to one-hot enables. All zero when the row gates nothing.
module useq_reg_dec
    import useq_pkg::*;
(
    input  logic           reg_en,
    input  logic           reg_dst,
    input  logic [IRW-1:0] ir_q,
    output logic [NREG-1:0] reg_gate
);
    logic [RW-1:0] sel;

    // Stage one: field choice
    always_comb begin
        sel = reg_dst ? ir_q[DST_LSB +: RW] : ir_q[SRC_LSB +: RW];
    end

    // Stage two: one line per register
    for (genvar g = 0; g < NREG; g++) begin : g_line
        assign reg_gate[g] = reg_en && (sel == RW'(g));
    end
endmodule

// File: rtl/useq_top.sv
// Microprogram sequencer top: microprogram counter and instruction register
// around the control store, start generator, next-address logic and register
// decoder. Synchronous active-low reset returns to the fetch routine at 000.
module useq_top
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ir_load,
    input  logic [15:0]     ir_word,
    input  logic            flag_n,
    input  logic            flag_z,
    input  logic            ext_cond,
    input  logic            mfc,
    output logic [8:0]      upc,
    output logic            uop_end,
    output logic            uop_wait,
    output logic [15:0]     reg_gate
);
    logic [UAW-1:0] upc_q;
    logic [UAW-1:0] upc_nxt;
    logic [UAW-1:0] start_addr;
    logic [IRW-1:0] ir_q;
    uinstr_t        uw;

    useq_store u_store (.addr(upc_q), .uw(uw));

    useq_start_gen u_start (.ir_word(ir_word), .start_addr(start_addr));

    useq_next u_next (
        .upc(upc_q), .uw(uw), .ir_load(ir_load), .start_addr(start_addr),
        .ir_q(ir_q), .flag_n(flag_n), .flag_z(flag_z), .ext_cond(ext_cond),
        .mfc(mfc), .upc_nxt(upc_nxt)
    );

    useq_reg_dec u_rdec (
        .reg_en(uw.reg_en), .reg_dst(uw.reg_dst), .ir_q(ir_q), .reg_gate(reg_gate)
    );

    // Microprogram counter
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= '0;
        else        upc_q <= upc_nxt;
    end

    // Instruction register capture
    always_ff @(posedge clk) begin
        if (!rst_n)       ir_q <= '0;
        else if (ir_load) ir_q <= ir_word;
    end

    assign upc      = upc_q;
    assign uop_end  = uw.end_op;
    assign uop_wait = uw.wait_mem;
endmodule

// File: rtl/useq_checker.sv
// Port-level properties of the sequencer, bound to every useq_top instance.
module useq_checker
    import useq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ir_load,
    input logic [15:0]     ir_word,
    input logic            mfc,
    input logic [8:0]      upc,
    input logic            uop_end,
    input logic            uop_wait,
    input logic [15:0]     reg_gate
);
    // R7: a pending memory wait freezes the counter
    a_r7_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_wait && !mfc) |=> $stable(upc));

    // R3: a new instruction jumps to its entry row
    a_r3_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_load && !(uop_wait && !mfc)) |=>
        (upc == {1'b0, $past(ir_word[OP_LSB +: OPW]), {SLOTB{1'b0}}}));

    // R4: an end row returns to the fetch routine
    a_r4_end_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_end && !ir_load && !(uop_wait && !mfc)) |=> (upc == '0));

    // R9: at most one register is gated
    a_r9_gate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_gate));

    // R1: the first cycle out of reset starts at the fetch row
    a_r1_reset_fetch: assert property (@(posedge clk)
        !rst_n |=> (upc == '0));
endmodule

bind useq_top useq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_word(ir_word), .mfc(mfc),
    .upc(upc), .uop_end(uop_end), .uop_wait(uop_wait), .reg_gate(reg_gate)
);

// File: tb/tb_useq_top.sv
`timescale 1ns/1ps
module tb_useq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic [15:0] ir_word = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, ext_cond = 1'b0, mfc = 1'b0;
    logic [8:0]  upc;
    logic        uop_end, uop_wait;
    logic [15:0] reg_gate;

    int checks = 0;
    int errors = 0;
    int m_upc = 0;
    logic [15:0] m_ir = '0;

    useq_top dut (.*);

    always #2 clk = ~clk;

    // Behavioural description of the test table (R10)
    function automatic void row(input int a, output bit w, output bit e,
                                output bit b, output int cs, output int os,
                                output int tgt, output bit re, output bit rd);
        w = 0; e = 0; b = 0; cs = 0; os = 0; tgt = 0; re = 0; rd = 0;
        if (a >= 'o100 && a <= 'o137) e = 1;
        if (a == 'o001) w = 1;
        if (a == 'o003 || a == 'o171 || a == 'o021 || a == 'o031 ||
            a == 'o041 || a == 'o062) e = 1;
        if (a == 'o010) begin b = 1; tgt = 'o170; os = 1; end
        if (a == 'o020) begin b = 1; cs = 1; tgt = 'o100; end
        if (a == 'o030) begin b = 1; cs = 2; tgt = 'o104; os = 2; end
        if (a == 'o040) begin b = 1; cs = 3; tgt = 'o120; os = 3; end
        if (a == 'o050) begin w = 1; b = 1; tgt = 'o130; end
        if (a == 'o060) re = 1;
        if (a == 'o061) begin re = 1; rd = 1; end
    endfunction

    function automatic logic [15:0] mkw(input int op, input int md,
                                        input int ind, input int s, input int d);
        return {op[4:0], md[1:0], ind[0], s[3:0], d[3:0]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0o expected %0o", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        bit w, e, b, re, rd; int cs, os, tgt; int g;
        row(m_upc, w, e, b, cs, os, tgt, re, rd);
        g = re ? (1 << (rd ? m_ir[3:0] : m_ir[7:4])) : 0;
        chk(tag, int'(upc), m_upc, "upc");
        chk(tag, int'(reg_gate), g, "reg_gate");
        chk("R10", int'(uop_end), int'(e), "uop_end");
        chk("R10", int'(uop_wait), int'(w), "uop_wait");
    endtask

    // One clock of stimulus plus reference-model update and comparison
    task automatic step(input string tag, input bit ld, input logic [15:0] wd,
                        input bit n, input bit z, input bit x, input bit m);
        bit w, e, b, re, rd; int cs, os, tgt, nxt, orb; bit c;
        ir_load = ld; ir_word = wd; flag_n = n; flag_z = z; ext_cond = x; mfc = m;
        row(m_upc, w, e, b, cs, os, tgt, re, rd);
        c = (cs == 0) ? 1'b1 : (cs == 1) ? n : (cs == 2) ? z : x;
        orb = 0;
        if (os == 1 || os == 3) orb = orb | int'(!m_ir[8]);
        if (os == 2) orb = orb | int'(m_ir[10:9]);
        if (os == 3) orb = orb | (int'(m_ir[10:9]) << 1);
        if (w && !m)      nxt = m_upc;
        else if (ld)      nxt = int'(wd[15:11]) * 8;
        else if (e)       nxt = 0;
        else if (b && c)  nxt = tgt | orb;
        else              nxt = (m_upc + 1) % 512;
        @(posedge clk);
        #1;
        m_upc = nxt;
        if (ld) m_ir = wd;
        check_outs(tag);
    endtask

    task automatic idle(input string tag, input bit m);
        step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, m);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check_outs("R1");
        rst_n = 1'b1;
        m_upc = 0;
        // R2 fetch path, R7 wait with ir_load ignored by the counter
        idle("R2", 1);
        idle("R7", 0);
        step("R7", 1, mkw(6, 0, 0, 9, 3), 0, 0, 0, 0);
        idle("R7", 0);
        idle("R2", 1);
        idle("R2", 1);
        idle("R4", 1);
        // R3, R6 indirect then direct dispatch
        step("R3", 1, mkw(1, 0, 1, 0, 0), 0, 0, 0, 1);
        idle("R6", 1);
        idle("R2", 1);
        idle("R4", 1);
        step("R3", 1, mkw(1, 0, 0, 0, 0), 0, 0, 0, 1);
        idle("R6", 1);
        idle("R4", 1);
        // R5 condition selects, taken and not taken
        step("R3", 1, mkw(2, 0, 0, 0, 0), 0, 0, 0, 1);
        step("R5", 0, 0, 1, 0, 0, 1);
        idle("R4", 1);
        step("R3", 1, mkw(2, 0, 0, 0, 0), 0, 0, 0, 1);
        step("R5", 0, 0, 0, 1, 1, 1);
        idle("R4", 1);
        step("R3", 1, mkw(3, 2, 0, 0, 0), 0, 0, 0, 1);
        step("R6", 0, 0, 0, 1, 0, 1);
        idle("R4", 1);
        step("R3", 1, mkw(3, 2, 0, 0, 0), 0, 0, 0, 1);
        step("R5", 0, 0, 1, 0, 1, 1);
        idle("R4", 1);
        step("R3", 1, mkw(4, 3, 0, 0, 0), 0, 0, 0, 1);
        step("R6", 0, 0, 0, 0, 1, 1);
        idle("R4", 1);
        step("R3", 1, mkw(4, 1, 1, 0, 0), 0, 0, 0, 1);
        step("R6", 0, 0, 0, 0, 1, 1);
        idle("R4", 1);
        // R7 wait combined with a branch
        step("R3", 1, mkw(5, 0, 0, 0, 0), 0, 0, 0, 1);
        idle("R7", 0);
        idle("R7", 0);
        idle("R7", 1);
        idle("R4", 1);
        // R9 two-stage register gating
        step("R3", 1, mkw(6, 0, 0, 5, 12), 0, 0, 0, 1);
        idle("R9", 1);
        idle("R9", 1);
        idle("R4", 1);
        // R8 new instruction beats end and a taken branch
        idle("R2", 1);
        idle("R2", 1);
        idle("R2", 1);
        step("R8", 1, mkw(2, 0, 0, 0, 0), 0, 0, 0, 1);
        idle("R4", 1);
        step("R3", 1, mkw(1, 0, 0, 0, 0), 0, 0, 0, 1);
        step("R8", 1, mkw(6, 0, 0, 2, 7), 0, 0, 0, 1);
        idle("R9", 1);
        // R1 reset again mid-routine
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_upc = 0; m_ir = '0;
        check_outs("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule